// File: doc/BRIEF.md
# Binary-Weighted LED Bit-Plane Scan Controller

This block drives static full-color LED modules with binary-weighted bit-plane modulation of 10-bit gray data. For each bit position it fetches one bit of every channel of every pixel from an external frame source, shifts that bit-plane out on four ports (three serial lines per port: red, green, blue) with a shift clock, pulses a latch, and then raises a global enable. The enable stays high for a time in proportion to the binary weight of the latched bit. The time quantum comes from its own programmable divider, not from the serial shift rate, so refresh rate and luminous efficiency can be traded against each other by configuration.

Shifting and lighting overlap. While one plane is lit, the next plane is already being shifted. The plane that is shifted while bit 9 is lit is bit 0 of the following frame. A per-bit dark interval, in units of the quantum, can pad the frame to a fixed length. If a slot is too short to finish shifting, the latch waits and the enable stays low. Divider and dark-interval settings are sampled once per frame, when the bit-0 plane is latched.

The frame source has a one-cycle registered read. The controller presents a pixel index and a plane index with a read strobe. The source returns 12 plane bits for that pixel on the next cycle.

Top module: `bitplane_scan_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the enable, latch, shift clock and read strobe outputs are all low.
- R2: After plane k is latched, the enable is high for exactly 2^k x (D+1) clock cycles, where D is the divider setting in effect for the frame.
- R3: Between two latch pulses the shift clock rises exactly PIXELS times. At the i-th rising edge the serial data equals the source's word for pixel i of the plane being loaded, and the data does not change at any shift-clock rising edge. Data bit 3p is red, bit 3p+1 is green and bit 3p+2 is blue of port p.
- R4: The latch pulse is exactly two clock cycles (one shift-clock period) wide and is never high while the enable is high.
- R5: Let W be the lit time of plane k, O its dark setting (field k of the dark-interval bus, bits [k*OFF_W +: OFF_W]) times (D+1), and S = 2*PIXELS+2 the shift time of a plane. The number of cycles between the enable falling and the next latch rising, with both low, is max(O, S+1-W).
- R6: Planes are latched in the cyclic order 0,1,...,9,0. The next plane's shift-clock edges occur while the current plane is lit, so all PIXELS edges of bit 0 fall inside bit 9's enable window.
- R7: A change of the divider or dark-interval inputs during a frame has no effect on that frame. It takes effect from the next latch of plane 0.
- R8: The read strobe is never high on two consecutive cycles, and the source word is taken from the cycle after the strobe.
- R9: The shift clock is high for one clock cycle at a time, and the controller neither shifts nor reads while the latch is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_i | input | DIV_W | Quantum divider D; one quantum is D+1 cycles |
| cfg_off_i | input | GRAY_BITS*OFF_W | Dark interval per bit, in quanta, field k for bit k |
| rd_en_o | output | 1 | Read strobe to frame source |
| rd_addr_o | output | clog2(PIXELS) | Pixel index of the read |
| rd_plane_o | output | clog2(GRAY_BITS) | Bit-plane index of the read |
| rd_data_i | input | PORTS*3 | Plane bits of the pixel, valid the cycle after the strobe |
| sclk_o | output | 1 | Serial shift clock |
| sdata_o | output | PORTS*3 | Serial RGB data, three lines per port |
| latch_o | output | 1 | Latch pulse to driver chips |
| en_o | output | 1 | Global lighting enable |

## Verification
The checker watches the cycle-level rules on every cycle: latch and enable never overlap, the latch is two cycles wide, the shift clock is a one-cycle pulse with the serial data held steady at each rise, and reads are spaced and suppressed while latching. The binary-weighted enable widths, the dark gaps with their stretch when shifting overruns a slot, the per-plane data order and the once-per-frame capture of configuration depend on long, setting-dependent windows. Only the bench scenarios show these, by measuring whole frames under several divider and dark-interval settings and one change made in the middle of a frame.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_LATCH = 2'd1,
    ST_LIGHT = 2'd2,
    ST_DARK  = 2'd3
  } scan_state_t;

  function automatic int unsigned wrap_inc(int unsigned v, int unsigned modulus);
    return (v + 1 >= modulus) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/bp_unit_timer.sv
module bp_unit_timer #(
  parameter int DIV_W = 16,
  parameter int TW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TW-1:0]    units_i,
  output logic             last_o
);

  logic             run_q;
  logic [DIV_W-1:0] pre_q;
  logic [TW-1:0]    left_q;

  assign last_o = run_q && (pre_q == div_i) && (left_q == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      pre_q  <= '0;
      left_q <= units_i;
    end else if (run_q) begin
      if (pre_q == div_i) begin
        pre_q  <= '0;
        left_q <= left_q - TW'(1);
        if (left_q == TW'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/bp_plane_shifter.sv
module bp_plane_shifter #(
  parameter int PIXELS = 768,
  parameter int CH_W   = 12,
  parameter int AW     = 10,
  parameter int CW     = 10,
  parameter int PW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [PW-1:0]   plane_i,
  input  logic [CH_W-1:0] rd_data_i,
  output logic            done_o,
  output logic            rd_en_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic [PW-1:0]   rd_plane_o,
  output logic            sclk_o,
  output logic [CH_W-1:0] sdata_o
);

  localparam logic [CW-1:0] LAST = CW'(PIXELS);

  logic          active_q;
  logic          ph_q;
  logic [CW-1:0] pix_q;
  logic [PW-1:0] plane_q;

  assign rd_en_o    = active_q && !ph_q && (pix_q != LAST);
  assign rd_addr_o  = pix_q[AW-1:0];
  assign rd_plane_o = plane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ph_q     <= 1'b0;
      pix_q    <= '0;
      plane_q  <= '0;
      done_o   <= 1'b0;
      sclk_o   <= 1'b0;
      sdata_o  <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      ph_q     <= 1'b0;
      pix_q    <= '0;
      plane_q  <= plane_i;
      done_o   <= 1'b0;
    end else if (active_q) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        if (pix_q != '0) sclk_o <= 1'b1;
      end else begin
        sclk_o <= 1'b0;
        if (pix_q != LAST) begin
          sdata_o <= rd_data_i;
          pix_q   <= pix_q + CW'(1);
        end else begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bitplane_scan_ctrl.sv
module bitplane_scan_ctrl #(
  parameter int GRAY_BITS = 10,
  parameter int PORTS     = 4,
  parameter int PIXELS    = 768,
  parameter int DIV_W     = 16,
  parameter int OFF_W     = 12
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [DIV_W-1:0]                         cfg_div_i,
  input  logic [GRAY_BITS*OFF_W-1:0]               cfg_off_i,
  output logic                                     rd_en_o,
  output logic [(PIXELS > 1 ? $clog2(PIXELS) : 1)-1:0] rd_addr_o,
  output logic [$clog2(GRAY_BITS)-1:0]             rd_plane_o,
  input  logic [PORTS*3-1:0]                       rd_data_i,
  output logic                                     sclk_o,
  output logic [PORTS*3-1:0]                       sdata_o,
  output logic                                     latch_o,
  output logic                                     en_o
);
  import bp_pkg::*;

  localparam int CH_W = PORTS * 3;
  localparam int AW   = (PIXELS > 1) ? $clog2(PIXELS) : 1;
  localparam int CW   = $clog2(PIXELS + 1);
  localparam int PW   = $clog2(GRAY_BITS);
  localparam int TW   = (OFF_W > GRAY_BITS) ? OFF_W : GRAY_BITS;

  scan_state_t st_q;
  logic        started_q;
  logic        lat_ph_q;
  logic [PW-1:0] cur_q, nxt_q;
  logic [DIV_W-1:0] div_q;
  logic [GRAY_BITS-1:0][OFF_W-1:0] off_q;

  logic          sh_start, sh_done;
  logic [PW-1:0] sh_plane;
  logic          t_load, t_last;
  logic [TW-1:0] t_units;
  logic [OFF_W-1:0] cur_off;
  logic          go_latch;

  assign cur_off  = off_q[cur_q];
  assign sh_start = ((st_q == ST_WAIT) && !started_q) || ((st_q == ST_LATCH) && lat_ph_q);
  assign sh_plane = started_q ? PW'(wrap_inc(32'(cur_q), GRAY_BITS)) : '0;

  assign go_latch = sh_done && (((st_q == ST_WAIT) && started_q) ||
                                ((st_q == ST_DARK) && t_last) ||
                                ((st_q == ST_LIGHT) && t_last && (cur_off == '0)));

  assign t_load  = ((st_q == ST_LATCH) && lat_ph_q) ||
                   ((st_q == ST_LIGHT) && t_last && (cur_off != '0));
  assign t_units = (st_q == ST_LATCH) ? (TW'(1) << cur_q) : TW'(cur_off);

  bp_unit_timer #(.DIV_W(DIV_W), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load_i(t_load), .div_i(div_q),
    .units_i(t_units), .last_o(t_last)
  );

  bp_plane_shifter #(.PIXELS(PIXELS), .CH_W(CH_W), .AW(AW), .CW(CW), .PW(PW)) u_shift (
    .clk(clk), .rst(rst), .start_i(sh_start), .plane_i(sh_plane),
    .rd_data_i(rd_data_i), .done_o(sh_done), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .rd_plane_o(rd_plane_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_WAIT;
      started_q <= 1'b0;
      lat_ph_q  <= 1'b0;
      cur_q     <= '0;
      nxt_q     <= '0;
      div_q     <= '0;
      off_q     <= '0;
      en_o      <= 1'b0;
      latch_o   <= 1'b0;
    end else begin
      if (sh_start) nxt_q <= sh_plane;
      case (st_q)
        ST_WAIT: if (!started_q) started_q <= 1'b1;
        ST_LATCH: begin
          if (lat_ph_q) begin
            lat_ph_q <= 1'b0;
            latch_o  <= 1'b0;
            en_o     <= 1'b1;
            st_q     <= ST_LIGHT;
          end else begin
            lat_ph_q <= 1'b1;
          end
        end
        ST_LIGHT: begin
          if (t_last) begin
            en_o <= 1'b0;
            if (cur_off != '0) st_q <= ST_DARK;
            else               st_q <= ST_WAIT;
          end
        end
        default: if (t_last) st_q <= ST_WAIT;
      endcase
      if (go_latch) begin
        st_q     <= ST_LATCH;
        latch_o  <= 1'b1;
        lat_ph_q <= 1'b0;
        cur_q    <= nxt_q;
        if (nxt_q == '0) begin
          div_q <= cfg_div_i;
          off_q <= cfg_off_i;
        end
      end
    end
  end

endmodule

// File: rtl/bp_scan_chk.sv
module bp_scan_chk #(
  parameter int CH = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          latch,
  input logic          sclk,
  input logic [CH-1:0] sdata,
  input logic          rd_en
);

  // R4
  latch_vs_en_chk: assert property (@(posedge clk) disable iff (rst) !(latch && en));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst) $rose(latch) |=> latch);
  // R4
  latch_end_chk: assert property (@(posedge clk) disable iff (rst) (latch && $past(latch)) |=> !latch);
  // R9
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (rst) sclk |=> !sclk);
  // R3
  sdata_stable_chk: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> $stable(sdata));
  // R8
  rd_spacing_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> !rd_en);
  // R9
  latch_quiet_chk: assert property (@(posedge clk) disable iff (rst) latch |-> (!sclk && !rd_en));

endmodule

bind bitplane_scan_ctrl bp_scan_chk #(.CH(CH_W)) u_chk (
  .clk(clk), .rst(rst), .en(en_o), .latch(latch_o),
  .sclk(sclk_o), .sdata(sdata_o), .rd_en(rd_en_o)
);

// File: tb/bitplane_scan_ctrl_bench.sv
module bitplane_scan_ctrl_bench;

  localparam int GB    = 10;
  localparam int PORTS = 4;
  localparam int PIX   = 8;
  localparam int DIV_W = 16;
  localparam int OFF_W = 12;
  localparam int CH    = PORTS * 3;
  localparam int AW    = $clog2(PIX);
  localparam int PW    = $clog2(GB);
  localparam int SHIFT = 2 * PIX + 2;
  // {divider, dark scale}; dark interval of bit k = scale*(9-k)
  localparam int VEC [4][2] = '{'{0, 0}, '{2, 1}, '{1, 3}, '{3, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0]    cfg_div = '0;
  logic [GB*OFF_W-1:0] cfg_off = '0;
  logic rd_en, sclk, latch, en;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] rd_plane;
  logic [CH-1:0] rd_data = '0, sdata;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bitplane_scan_ctrl #(.GRAY_BITS(GB), .PORTS(PORTS), .PIXELS(PIX),
                       .DIV_W(DIV_W), .OFF_W(OFF_W)) u_bitplane_scan_ctrl (
    .clk(clk), .rst(rst), .cfg_div_i(cfg_div), .cfg_off_i(cfg_off),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_plane_o(rd_plane),
    .rd_data_i(rd_data), .sclk_o(sclk), .sdata_o(sdata),
    .latch_o(latch), .en_o(en)
  );

  function automatic logic [CH-1:0] pat(int a, int p);
    return CH'((a * 37 + p * 11 + a * p * 5) ^ 12'h5A3);
  endfunction

  // registered frame source, one-cycle latency (R8)
  always @(posedge clk) if (rd_en) rd_data <= pat(int'(rd_addr), int'(rd_plane));

  int w_meas[GB], g_meas[GB], d_err[GB], olap[GB];
  int lit, frame_cnt, en_cnt, gap_cnt, ncap;
  logic [CH-1:0] cap[PIX];
  logic p_en, p_sclk, p_latch;

  always @(negedge clk) begin
    if (rst) begin
      lit = -1; frame_cnt = 0; en_cnt = 0; gap_cnt = 0; ncap = 0;
      p_en = 0; p_sclk = 0; p_latch = 0;
    end else begin
      if (en) en_cnt++;
      if (!en && p_en) begin
        if (lit >= 0) w_meas[lit] = en_cnt;
        en_cnt = 0; gap_cnt = 0;
      end
      if (!en && !latch && lit >= 0) gap_cnt++;
      if (sclk && !p_sclk) begin
        if (ncap < PIX) cap[ncap] = sdata;
        ncap++;
        if (en && lit >= 0) olap[lit]++;
      end
      if (latch && !p_latch) begin
        int pl, e;
        if (lit >= 0) g_meas[lit] = gap_cnt;
        pl = (lit < 0) ? 0 : (lit + 1) % GB;
        e = (ncap != PIX) ? 1 : 0;
        for (int i = 0; i < PIX; i++) if (i < ncap && cap[i] !== pat(i, pl)) e++;
        d_err[pl] = e; ncap = 0; gap_cnt = 0;
        lit = pl; olap[pl] = 0;
        if (pl == 0) frame_cnt++;
      end
      p_en = en; p_sclk = sclk; p_latch = latch;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int d, int s);
    cfg_div = DIV_W'(d);
    for (int k = 0; k < GB; k++) cfg_off[k*OFF_W +: OFF_W] = OFF_W'(s * (GB - 1 - k));
  endtask

  function automatic int exp_gap(int k, int d, int s);
    int o, w;
    o = s * (GB - 1 - k) * (d + 1);
    w = (1 << k) * (d + 1);
    return (o > SHIFT + 1 - w) ? o : SHIFT + 1 - w;
  endfunction

  task automatic check_frame(int d, int s, string tag);
    for (int k = 0; k < GB; k++) begin
      chk($sformatf("R2 %s width bit%0d", tag, k), w_meas[k], (1 << k) * (d + 1));
      chk($sformatf("R5 %s gap bit%0d", tag, k), g_meas[k], exp_gap(k, d, s));
      chk($sformatf("R3 %s data bit%0d", tag, k), d_err[k], 0);
    end
    chk($sformatf("R6 %s bit0 shifted under bit9", tag), olap[GB-1], PIX);
  endtask

  task automatic wait_frames(int target);
    while (frame_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int fc;
    set_cfg(0, 0);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 en in reset", int'(en), 0);
    chk("R1 latch in reset", int'(latch), 0);
    chk("R1 sclk in reset", int'(sclk), 0);
    chk("R1 rd_en in reset", int'(rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 en after reset", int'(en), 0);
    chk("R1 latch after reset", int'(latch), 0);

    // vector walk: R2 R3 R5 R6 under several divider and dark settings
    for (int v = 0; v < 4; v++) begin
      set_cfg(VEC[v][0], VEC[v][1]);
      @(negedge clk);
      fc = frame_cnt;
      wait_frames(fc + 2);
      check_frame(VEC[v][0], VEC[v][1], $sformatf("vec%0d", v));
    end

    // R7: mid-frame configuration change applies only from the next frame
    set_cfg(1, 1);
    @(negedge clk);
    fc = frame_cnt;
    while (frame_cnt < fc + 1) @(negedge clk);
    while (lit != 3) @(negedge clk);
    set_cfg(2, 2);
    wait_frames(fc + 2);
    check_frame(1, 1, "R7 old-frame");
    wait_frames(fc + 3);
    check_frame(2, 2, "R7 new-frame");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule